// File: doc/BRIEF.md
# DMA Descriptor Loader

This block brings up one unit of DMA work for a channel. On a start strobe it snapshots the channel's register values. It decodes the element size and the flow mode from the config word and checks that the descriptor size suits that flow mode. When the configuration is legal, it fetches the descriptor words one at a time over a 16-bit memory read port. Each fetched word goes into a fixed register slot.

Once loading ends, the block works out the channel's current descriptor pointer, current address and current X/Y counts. It checks that the start address is aligned to the element size and pulses done. The updated register values are exported for write-back into the channel's register bank. Address generation and data movement belong to other blocks. The loader only prepares their starting state.

Config word fields used by the loader are:
- word-size code in bits [3:2];
- descriptor size (number of 16-bit words) in bits [11:8];
- flow code in bits [14:12].

Top module: `dma_desc_loader`

## Requirements
- R1: The element size reported on `elem_size_o` is 4 when the word-size code `cfg_i[3:2]` is 2'b10, 2 when it is 2'b01, and 1 for any other code.
- R2: If the final start address (after loading) is not a multiple of the element size, `align_err_o` is high in the done cycle; the load still completes.
- R3: Flow codes 3'b000 (stop) and 3'b001 (autobuffer) are legal only with a descriptor size of zero; any other size raises `cfg_err_o`.
- R4: Flow code 3'b100 (array) takes sizes 1..7 and fetches from `desc_ptr_i`. Flow code 3'b110 (small list) takes sizes 1..8 and flow code 3'b111 (large list) takes sizes 1..9; both fetch from `next_ptr_i`. Flow codes 3'b010, 3'b011 and 3'b101 are always a configuration error.
- R5: On a configuration error the block issues no memory request and pulses `done_o` with `cfg_err_o` high. The current-value outputs keep their previous values, and the write-back outputs show the values presented at start.
- R6: One request is made per descriptor word. The first request goes to the fetch pointer and each later one is 2 bytes higher.
- R7: Fetched words fill slots in a fixed sequence: next-pointer low, next-pointer high, start-address low, start-address high, config, X count, X modify, Y count, Y modify. Large-list mode starts at next-pointer low. Small-list mode fills next-pointer low and then skips to start-address low. Array mode starts at start-address low. Slots not fetched keep the start values.
- R8: At done, `cur_desc_ptr_o` equals the next pointer and `cur_addr_o` equals the start address. `cur_x_count_o`/`cur_y_count_o` equal the X/Y counts, with a count of zero replaced by 16'hFFFF.
- R9: A request holds `mem_addr_o` steady until `mem_ready_i`. Read data is taken only when `mem_rvalid_i` is high, after any latency.
- R10: A start strobe while a load is in progress is ignored.
- R11: `done_o` is a one-cycle pulse. A start strobe in the done cycle begins the next load immediately.
- R12: After reset, `done_o`, `mem_req_o`, both error flags and all current-value outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (accepted when idle or in the done cycle) |
| cfg_i | input | WORD_W | Config word at start |
| next_ptr_i | input | 2*WORD_W | Next descriptor pointer at start |
| desc_ptr_i | input | 2*WORD_W | Current descriptor pointer at start |
| start_addr_i | input | 2*WORD_W | Start address at start |
| x_count_i | input | WORD_W | X count at start |
| x_mod_i | input | WORD_W | X modify at start |
| y_count_i | input | WORD_W | Y count at start |
| y_mod_i | input | WORD_W | Y modify at start |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 2*WORD_W | Byte address of the requested word |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | WORD_W | Read data |
| wb_next_ptr_o | output | 2*WORD_W | Next pointer for write-back |
| wb_start_addr_o | output | 2*WORD_W | Start address for write-back |
| wb_cfg_o | output | WORD_W | Config for write-back |
| wb_x_count_o | output | WORD_W | X count for write-back |
| wb_x_mod_o | output | WORD_W | X modify for write-back |
| wb_y_count_o | output | WORD_W | Y count for write-back |
| wb_y_mod_o | output | WORD_W | Y modify for write-back |
| cur_desc_ptr_o | output | 2*WORD_W | Current descriptor pointer |
| cur_addr_o | output | 2*WORD_W | Current address |
| cur_x_count_o | output | WORD_W | Current X count |
| cur_y_count_o | output | WORD_W | Current Y count |
| elem_size_o | output | 3 | Element size in bytes |
| align_err_o | output | 1 | Start address misaligned |
| cfg_err_o | output | 1 | Flow/size combination illegal |
| done_o | output | 1 | Load finished (one cycle) |

## Verification
The done pulse of one load can coincide with the acceptance of the next start. The bench drives a new start in the exact cycle `done_o` is seen. It first checks the finished load's outputs in that cycle, then checks that the second load completes with its own values computed from the requirements. The bench also raises a start strobe in the middle of a fetch. It judges that strobe by confirming that the first load's results are unchanged and that no extra done pulse appears.

// File: rtl/dmadl_pkg.sv
package dmadl_pkg;
    localparam int WSZ_LSB  = 2;
    localparam int NDS_LSB  = 8;
    localparam int NDS_W    = 4;
    localparam int FLOW_LSB = 12;
    localparam int FLOW_W   = 3;

    localparam logic [FLOW_W-1:0] FL_STOP  = 3'b000;
    localparam logic [FLOW_W-1:0] FL_AUTO  = 3'b001;
    localparam logic [FLOW_W-1:0] FL_ARRAY = 3'b100;
    localparam logic [FLOW_W-1:0] FL_SMALL = 3'b110;
    localparam logic [FLOW_W-1:0] FL_LARGE = 3'b111;

    localparam int MAX_ARRAY = 7;
    localparam int MAX_SMALL = 8;
    localparam int MAX_LARGE = 9;

    localparam int NSLOT  = 9;
    localparam int SLOT_W = $clog2(NSLOT);

    localparam int SL_NP_LO = 0;
    localparam int SL_NP_HI = 1;
    localparam int SL_SA_LO = 2;
    localparam int SL_SA_HI = 3;
    localparam int SL_CFG   = 4;
    localparam int SL_XC    = 5;
    localparam int SL_XM    = 6;
    localparam int SL_YC    = 7;
    localparam int SL_YM    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FIN,
        ST_DONE
    } state_e;
endpackage

// File: rtl/dmadl_cfg_decode.sv
module dmadl_cfg_decode
    import dmadl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      cfg,
    output logic [2:0]        esize,
    output logic [FLOW_W-1:0] flow,
    output logic [NDS_W-1:0]  nd,
    output logic              legal,
    output logic              from_cur
);
    logic [1:0] wsz;

    always_comb begin
        wsz  = cfg[WSZ_LSB +: 2];
        flow = cfg[FLOW_LSB +: FLOW_W];
        nd   = cfg[NDS_LSB +: NDS_W];

        case (wsz)
            2'b10:   esize = 3'd4;
            2'b01:   esize = 3'd2;
            default: esize = 3'd1;
        endcase

        // R3 / R4: legal descriptor size per flow mode
        case (flow)
            FL_STOP, FL_AUTO: legal = (nd == '0);
            FL_ARRAY:         legal = (nd != '0) && (nd <= NDS_W'(MAX_ARRAY));
            FL_SMALL:         legal = (nd != '0) && (nd <= NDS_W'(MAX_SMALL));
            FL_LARGE:         legal = (nd != '0) && (nd <= NDS_W'(MAX_LARGE));
            default:          legal = 1'b0;
        endcase

        from_cur = (flow == FL_ARRAY);
    end
endmodule

// File: rtl/dmadl_slot_map.sv
module dmadl_slot_map
    import dmadl_pkg::*;
(
    input  logic [FLOW_W-1:0] flow,
    input  logic [NDS_W-1:0]  idx,
    output logic [SLOT_W-1:0] slot
);
    // R7: positional placement of fetched words
    always_comb begin
        case (flow)
            FL_LARGE: slot = SLOT_W'(idx);
            FL_SMALL: slot = (idx == '0) ? SLOT_W'(SL_NP_LO) : SLOT_W'(idx + NDS_W'(1));
            FL_ARRAY: slot = SLOT_W'(idx + NDS_W'(SL_SA_LO));
            default:  slot = SLOT_W'(idx);
        endcase
    end
endmodule

// File: rtl/dmadl_slot_file.sv
module dmadl_slot_file
    import dmadl_pkg::*;
#(
    parameter int W = 16,
    parameter int N = NSLOT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [N-1:0][W-1:0]   init_i,
    input  logic                  wr_i,
    input  logic [SLOT_W-1:0]     wr_slot_i,
    input  logic [W-1:0]          wr_data_i,
    output logic [N-1:0][W-1:0]   slots_o
);
    logic [N-1:0][W-1:0] slot_d, slot_q;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (load_i) begin
                slot_d[g] = init_i[g];
            end else if (wr_i && (wr_slot_i == SLOT_W'(g))) begin
                slot_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign slots_o = slot_q;
endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
    import dmadl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [WORD_W-1:0]     cfg_i,
    input  logic [2*WORD_W-1:0]   next_ptr_i,
    input  logic [2*WORD_W-1:0]   desc_ptr_i,
    input  logic [2*WORD_W-1:0]   start_addr_i,
    input  logic [WORD_W-1:0]     x_count_i,
    input  logic [WORD_W-1:0]     x_mod_i,
    input  logic [WORD_W-1:0]     y_count_i,
    input  logic [WORD_W-1:0]     y_mod_i,
    output logic                  mem_req_o,
    output logic [2*WORD_W-1:0]   mem_addr_o,
    input  logic                  mem_ready_i,
    input  logic                  mem_rvalid_i,
    input  logic [WORD_W-1:0]     mem_rdata_i,
    output logic [2*WORD_W-1:0]   wb_next_ptr_o,
    output logic [2*WORD_W-1:0]   wb_start_addr_o,
    output logic [WORD_W-1:0]     wb_cfg_o,
    output logic [WORD_W-1:0]     wb_x_count_o,
    output logic [WORD_W-1:0]     wb_x_mod_o,
    output logic [WORD_W-1:0]     wb_y_count_o,
    output logic [WORD_W-1:0]     wb_y_mod_o,
    output logic [2*WORD_W-1:0]   cur_desc_ptr_o,
    output logic [2*WORD_W-1:0]   cur_addr_o,
    output logic [WORD_W-1:0]     cur_x_count_o,
    output logic [WORD_W-1:0]     cur_y_count_o,
    output logic [2:0]            elem_size_o,
    output logic                  align_err_o,
    output logic                  cfg_err_o,
    output logic                  done_o
);
    localparam int W = WORD_W;
    localparam int A = 2 * WORD_W;

    typedef struct packed {
        state_e             st;
        logic [FLOW_W-1:0]  flow;
        logic [NDS_W-1:0]   nd;
        logic [NDS_W-1:0]   idx;
        logic [A-1:0]       ptr;
        logic [2:0]         esize;
        logic               cfg_err;
        logic               align_err;
        logic [A-1:0]       cdp;
        logic [A-1:0]       caddr;
        logic [W-1:0]       cx;
        logic [W-1:0]       cy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [2:0]             dec_esize;
    logic [FLOW_W-1:0]      dec_flow;
    logic [NDS_W-1:0]       dec_nd;
    logic                   dec_legal;
    logic                   dec_from_cur;

    logic                   load;
    logic                   wr;
    logic [SLOT_W-1:0]      wr_slot;
    logic [NSLOT-1:0][W-1:0] init_vals;
    logic [NSLOT-1:0][W-1:0] slots;

    logic [A-1:0]           fin_sa;

    dmadl_cfg_decode #(.W(W)) u_dec (
        .cfg      (cfg_i),
        .esize    (dec_esize),
        .flow     (dec_flow),
        .nd       (dec_nd),
        .legal    (dec_legal),
        .from_cur (dec_from_cur)
    );

    dmadl_slot_map u_map (
        .flow (ctl_q.flow),
        .idx  (ctl_q.idx),
        .slot (wr_slot)
    );

    assign init_vals = {y_mod_i, y_count_i, x_mod_i, x_count_i, cfg_i,
                        start_addr_i[A-1:W], start_addr_i[W-1:0],
                        next_ptr_i[A-1:W], next_ptr_i[W-1:0]};

    dmadl_slot_file #(.W(W), .N(NSLOT)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .init_i    (init_vals),
        .wr_i      (wr),
        .wr_slot_i (wr_slot),
        .wr_data_i (mem_rdata_i),
        .slots_o   (slots)
    );

    assign fin_sa = {slots[SL_SA_HI], slots[SL_SA_LO]};

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        wr    = 1'b0;

        case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    load            = 1'b1;
                    ctl_d.flow      = dec_flow;
                    ctl_d.nd        = dec_nd;
                    ctl_d.idx       = '0;
                    ctl_d.esize     = dec_esize;
                    ctl_d.ptr       = dec_from_cur ? desc_ptr_i : next_ptr_i;
                    ctl_d.cfg_err   = !dec_legal;
                    ctl_d.align_err = 1'b0;
                    if (!dec_legal || (dec_nd == '0)) begin
                        ctl_d.st = ST_FIN;
                    end else begin
                        ctl_d.st = ST_REQ;
                    end
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_REQ: begin
                if (mem_ready_i) begin
                    ctl_d.ptr = ctl_q.ptr + A'(2);
                    ctl_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    wr        = 1'b1;
                    ctl_d.idx = ctl_q.idx + NDS_W'(1);
                    if ((ctl_q.idx + NDS_W'(1)) == ctl_q.nd) begin
                        ctl_d.st = ST_FIN;
                    end else begin
                        ctl_d.st = ST_REQ;
                    end
                end
            end
            ST_FIN: begin
                if (!ctl_q.cfg_err) begin
                    ctl_d.cdp       = {slots[SL_NP_HI], slots[SL_NP_LO]};
                    ctl_d.caddr     = fin_sa;
                    ctl_d.cx        = (slots[SL_XC] == '0) ? '1 : slots[SL_XC];
                    ctl_d.cy        = (slots[SL_YC] == '0) ? '1 : slots[SL_YC];
                    ctl_d.align_err = |(fin_sa[2:0] & (ctl_q.esize - 3'd1));
                end
                ctl_d.st = ST_DONE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req_o       = (ctl_q.st == ST_REQ);
    assign mem_addr_o      = ctl_q.ptr;
    assign done_o          = (ctl_q.st == ST_DONE);
    assign elem_size_o     = ctl_q.esize;
    assign cfg_err_o       = ctl_q.cfg_err;
    assign align_err_o     = ctl_q.align_err;
    assign cur_desc_ptr_o  = ctl_q.cdp;
    assign cur_addr_o      = ctl_q.caddr;
    assign cur_x_count_o   = ctl_q.cx;
    assign cur_y_count_o   = ctl_q.cy;

    assign wb_next_ptr_o   = {slots[SL_NP_HI], slots[SL_NP_LO]};
    assign wb_start_addr_o = fin_sa;
    assign wb_cfg_o        = slots[SL_CFG];
    assign wb_x_count_o    = slots[SL_XC];
    assign wb_x_mod_o      = slots[SL_XM];
    assign wb_y_count_o    = slots[SL_YC];
    assign wb_y_mod_o      = slots[SL_YM];
endmodule

// File: rtl/dmadl_checker.sv
module dmadl_checker #(
    parameter int W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req_o,
    input logic [2*W-1:0]   mem_addr_o,
    input logic             mem_ready_i,
    input logic             done_o,
    input logic             cfg_err_o,
    input logic [2*W-1:0]   cur_addr_o,
    input logic [W-1:0]     cur_x_count_o,
    input logic [W-1:0]     cur_y_count_o
);
    logic [2*W-1:0] last_acc_q;
    logic           have_acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_acc_q <= '0;
            have_acc_q <= 1'b0;
        end else if (done_o) begin
            have_acc_q <= 1'b0;
        end else if (mem_req_o && mem_ready_i) begin
            last_acc_q <= mem_addr_o;
            have_acc_q <= 1'b1;
        end
    end

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && have_acc_q |-> mem_addr_o == last_acc_q + (2*W)'(2));

    a_r5_no_fetch_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !mem_req_o);

    a_r5_cur_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && cfg_err_o |-> $stable(cur_addr_o) && $stable(cur_x_count_o));

    a_r8_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !cfg_err_o |-> (cur_x_count_o != '0) && (cur_y_count_o != '0));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind dma_desc_loader dmadl_checker #(.W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ready_i   (mem_ready_i),
    .done_o        (done_o),
    .cfg_err_o     (cfg_err_o),
    .cur_addr_o    (cur_addr_o),
    .cur_x_count_o (cur_x_count_o),
    .cur_y_count_o (cur_y_count_o)
);

// File: tb/sim_dma_desc_loader.sv
module sim_dma_desc_loader;
    localparam int W = 16;
    localparam int A = 32;

    typedef struct packed {
        logic [15:0] cfg;
        logic [31:0] np;
        logic [31:0] cdp;
        logic [31:0] sa;
        logic [15:0] xc;
        logic [15:0] xm;
        logic [15:0] yc;
        logic [15:0] ym;
        logic        cerr;
        logic [3:0]  nr;
    } vec_t;

    // cfg = flow<<12 | size<<8 | wsize<<2
    localparam vec_t VECS [12] = '{
        '{16'h0008, 32'h40, 32'h20, 32'h100,  16'h0000, 16'h4, 16'h3, 16'h4, 1'b0, 4'd0},
        '{16'h1004, 32'h40, 32'h20, 32'h101,  16'h0010, 16'h2, 16'h0, 16'h2, 1'b0, 4'd0},
        '{16'h0200, 32'h40, 32'h20, 32'h2000, 16'h0001, 16'h1, 16'h1, 16'h1, 1'b1, 4'd0},
        '{16'h4700, 32'h40, 32'h20, 32'h2000, 16'h0005, 16'h1, 16'h1, 16'h1, 1'b0, 4'd7},
        '{16'h4800, 32'h40, 32'h20, 32'h2000, 16'h0005, 16'h1, 16'h1, 16'h1, 1'b1, 4'd0},
        '{16'h6804, 32'h40, 32'h20, 32'h2000, 16'h0005, 16'h2, 16'h1, 16'h2, 1'b0, 4'd8},
        '{16'h6000, 32'h40, 32'h20, 32'h2000, 16'h0005, 16'h1, 16'h1, 16'h1, 1'b1, 4'd0},
        '{16'h7908, 32'h10, 32'h20, 32'h2000, 16'h0005, 16'h4, 16'h1, 16'h4, 1'b0, 4'd9},
        '{16'h7A00, 32'h10, 32'h20, 32'h2000, 16'h0005, 16'h1, 16'h1, 16'h1, 1'b1, 4'd0},
        '{16'h2100, 32'h10, 32'h20, 32'h2000, 16'h0005, 16'h1, 16'h1, 16'h1, 1'b1, 4'd0},
        '{16'h7308, 32'h30, 32'h20, 32'h2000, 16'h0007, 16'h4, 16'h0, 16'h4, 1'b0, 4'd3},
        '{16'h410C, 32'h40, 32'h22, 32'h2001, 16'h0009, 16'h1, 16'h2, 16'h1, 1'b0, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          start_i = 1'b0;
    logic [W-1:0]  cfg_i = '0;
    logic [A-1:0]  next_ptr_i = '0, desc_ptr_i = '0, start_addr_i = '0;
    logic [W-1:0]  x_count_i = '0, x_mod_i = '0, y_count_i = '0, y_mod_i = '0;
    logic          mem_req_o;
    logic [A-1:0]  mem_addr_o;
    logic          mem_ready_i = 1'b1;
    logic          mem_rvalid_i = 1'b0;
    logic [W-1:0]  mem_rdata_i = '0;
    logic [A-1:0]  wb_next_ptr_o, wb_start_addr_o, cur_desc_ptr_o, cur_addr_o;
    logic [W-1:0]  wb_cfg_o, wb_x_count_o, wb_x_mod_o, wb_y_count_o, wb_y_mod_o;
    logic [W-1:0]  cur_x_count_o, cur_y_count_o;
    logic [2:0]    elem_size_o;
    logic          align_err_o, cfg_err_o, done_o;

    dma_desc_loader #(.WORD_W(W)) u0 (.*);

    logic [15:0] mem [64];
    int nchk = 0;
    int nfail = 0;

    // memory responder state
    bit          stall_mode = 1'b0;
    int          lat = 0;
    bit          acc_pend = 1'b0;
    int          cnt = 0;
    logic [31:0] acc_addr = '0;
    int          nreq = 0;
    logic [31:0] req_log [16];
    int          hold_viol = 0;
    bit          prev_req = 1'b0, prev_rdy = 1'b0;
    logic [31:0] prev_addr = '0;
    int          cyc = 0;

    // expectations
    logic [15:0] e_slot [9];
    logic [2:0]  e_es;
    logic        e_cerr, e_al;
    int          e_nr;
    logic [31:0] e_ptr, e_cdp, e_ca;
    logic [15:0] e_cx, e_cy;
    logic [31:0] p_ca, p_cdp;
    logic [15:0] p_cx, p_cy;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid_i = 1'b0;
            if (acc_pend) begin
                if (cnt == 0) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = mem[acc_addr[6:1]];
                    acc_pend     = 1'b0;
                end else begin
                    cnt--;
                end
            end
            if (prev_req && !prev_rdy && (!mem_req_o || mem_addr_o != prev_addr))
                hold_viol++;
            mem_ready_i = stall_mode ? (cyc % 3 == 2) : 1'b1;
            cyc++;
            if (mem_req_o && mem_ready_i) begin
                acc_pend = 1'b1;
                cnt      = lat;
                acc_addr = mem_addr_o;
                if (nreq < 16) req_log[nreq] = mem_addr_o;
                nreq++;
            end
            prev_req  = mem_req_o;
            prev_rdy  = mem_ready_i;
            prev_addr = mem_addr_o;
        end
    end

    // expected outcome from the requirements
    task automatic model(vec_t v);
        logic [2:0] flow;
        logic [3:0] nd;
        logic       ok;
        int         s;
        logic [31:0] a;
        e_slot[0] = v.np[15:0];  e_slot[1] = v.np[31:16];
        e_slot[2] = v.sa[15:0];  e_slot[3] = v.sa[31:16];
        e_slot[4] = v.cfg; e_slot[5] = v.xc; e_slot[6] = v.xm;
        e_slot[7] = v.yc;  e_slot[8] = v.ym;
        e_es = (v.cfg[3:2] == 2'b10) ? 3'd4 : (v.cfg[3:2] == 2'b01) ? 3'd2 : 3'd1;
        flow = v.cfg[14:12];
        nd   = v.cfg[11:8];
        case (flow)
            3'b000, 3'b001: ok = (nd == 0);
            3'b100: ok = (nd >= 1 && nd <= 7);
            3'b110: ok = (nd >= 1 && nd <= 8);
            3'b111: ok = (nd >= 1 && nd <= 9);
            default: ok = 1'b0;
        endcase
        e_cerr = !ok;
        e_ptr  = (flow == 3'b100) ? v.cdp : v.np;
        e_nr   = ok ? int'(nd) : 0;
        for (int k = 0; k < e_nr; k++) begin
            a = e_ptr + 32'(2 * k);
            s = (flow == 3'b111) ? k : (flow == 3'b110) ? ((k == 0) ? 0 : k + 1) : k + 2;
            e_slot[s] = mem[a[6:1]];
        end
        e_ca  = {e_slot[3], e_slot[2]};
        e_cdp = {e_slot[1], e_slot[0]};
        e_al  = ok && ((e_ca % 32'(e_es)) != 0);
        e_cx  = (e_slot[5] == 0) ? 16'hFFFF : e_slot[5];
        e_cy  = (e_slot[7] == 0) ? 16'hFFFF : e_slot[7];
    endtask

    task automatic launch(vec_t v);
        model(v);
        p_ca = cur_addr_o; p_cdp = cur_desc_ptr_o; p_cx = cur_x_count_o; p_cy = cur_y_count_o;
        nreq = 0;
        cfg_i = v.cfg; next_ptr_i = v.np; desc_ptr_i = v.cdp; start_addr_i = v.sa;
        x_count_i = v.xc; x_mod_i = v.xm; y_count_i = v.yc; y_mod_i = v.ym;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_and_check(vec_t v, string name);
        int t = 0;
        while (!done_o && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk("R11", {name, " done seen"}, 32'(done_o), 32'd1);
        if (!done_o) return;
        chk(v.cfg[14] ? "R4" : "R3", {name, " cfg_err"}, 32'(cfg_err_o), 32'(v.cerr));
        chk("R1", {name, " elem size"}, 32'(elem_size_o), 32'(e_es));
        chk("R6", {name, " request count"}, 32'(nreq), 32'(v.nr));
        for (int k = 0; k < nreq && k < 16; k++)
            chk("R6", {name, " request address"}, req_log[k], e_ptr + 32'(2 * k));
        chk("R7", {name, " wb next ptr"}, wb_next_ptr_o, {e_slot[1], e_slot[0]});
        chk("R7", {name, " wb start addr"}, wb_start_addr_o, {e_slot[3], e_slot[2]});
        chk("R7", {name, " wb cfg"}, 32'(wb_cfg_o), 32'(e_slot[4]));
        chk("R7", {name, " wb x count"}, 32'(wb_x_count_o), 32'(e_slot[5]));
        chk("R7", {name, " wb x mod"}, 32'(wb_x_mod_o), 32'(e_slot[6]));
        chk("R7", {name, " wb y count"}, 32'(wb_y_count_o), 32'(e_slot[7]));
        chk("R7", {name, " wb y mod"}, 32'(wb_y_mod_o), 32'(e_slot[8]));
        if (e_cerr) begin
            chk("R5", {name, " cur addr kept"}, cur_addr_o, p_ca);
            chk("R5", {name, " cur desc kept"}, cur_desc_ptr_o, p_cdp);
            chk("R5", {name, " cur x kept"}, 32'(cur_x_count_o), 32'(p_cx));
            chk("R5", {name, " cur y kept"}, 32'(cur_y_count_o), 32'(p_cy));
        end else begin
            chk("R2", {name, " align err"}, 32'(align_err_o), 32'(e_al));
            chk("R8", {name, " cur addr"}, cur_addr_o, e_ca);
            chk("R8", {name, " cur desc"}, cur_desc_ptr_o, e_cdp);
            chk("R8", {name, " cur x"}, 32'(cur_x_count_o), 32'(e_cx));
            chk("R8", {name, " cur y"}, 32'(cur_y_count_o), 32'(e_cy));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog: actual no completion expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        vec_t v;
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0104);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "done after reset", 32'(done_o), 32'd0);
        chk("R12", "req after reset", 32'(mem_req_o), 32'd0);
        chk("R12", "cfg err after reset", 32'(cfg_err_o), 32'd0);
        chk("R12", "cur addr after reset", cur_addr_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < 12; i++) begin
            launch(VECS[i]);
            finish_and_check(VECS[i], $sformatf("vec%0d", i));
            @(negedge clk);
        end

        // R8 zero counts replaced by all-ones
        mem[3] = 16'h0000;
        v = '{16'h4400, 32'h40, 32'h0, 32'h2000, 16'h5, 16'h1, 16'h0, 16'h1, 1'b0, 4'd4};
        launch(v);
        finish_and_check(v, "zero counts");
        chk("R8", "zero x count", 32'(cur_x_count_o), 32'hFFFF);
        chk("R8", "zero y count", 32'(cur_y_count_o), 32'hFFFF);
        mem[3] = 16'(3 * 16'h0104);
        @(negedge clk);

        // R9 stalls and response latency
        stall_mode = 1'b1;
        lat = 2;
        hold_viol = 0;
        launch(VECS[7]);
        finish_and_check(VECS[7], "stalled");
        chk("R9", "address held under stall", 32'(hold_viol), 32'd0);
        stall_mode = 1'b0;
        lat = 0;
        @(negedge clk);

        // R10 start while busy is ignored
        launch(VECS[7]);
        repeat (3) @(negedge clk);
        cfg_i = 16'h0008;
        start_addr_i = 32'h0000_0F00;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        finish_and_check(VECS[7], "busy start R10");
        begin
            int extra = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            chk("R10", "no extra done", 32'(extra), 32'd0);
        end

        // R11 back-to-back: start in the done cycle
        launch(VECS[10]);
        finish_and_check(VECS[10], "b2b first");
        launch(VECS[5]);
        finish_and_check(VECS[5], "b2b second R11");
        @(negedge clk);
        chk("R11", "done one cycle", 32'(done_o), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule